// File: doc/BRIEF.md
# Folded nine-tap FIR filter with a four-cycle shared datapath

The block filters a stream of 16-bit signed fixed-point samples: 1 sign bit, 5 integer bits and 10 fraction bits, so 1.0 is 0x0400. A sample is taken on any clock cycle where the strobe `sample_i` is high. The new sample becomes the newest entry of a nine-entry history. Over the next four cycles one pre-adder, one shift-add unit and one accumulator adder form the weighted sum of the whole history. That result is driven on `data_o` at the edge of the next strobe, and it is held there until the strobe after that.

The coefficients are fixed and mirror about the centre tap. The newest and the oldest sample share 0.125. The second newest and the second oldest share 0.25, the next pair shares -0.75 and the pair on either side of the centre shares 1.25. The centre sample has weight 1.0. Each mirrored pair is added before it is scaled, and every constant multiply is built from arithmetic right shifts and adds. The sum is kept 4 bits wider than a sample and is clamped to the 16-bit range only when it is loaded into the output register.

Top module: `fir_sym9`

## Requirements
- R1: With `rst_n` low at a clock edge (synchronous, active low), the output register, the accumulator and all nine history entries clear. The output reads 0x0000, and the strobes that follow with zero input give 0x0000 until a nonzero sample enters.
- R2: An impulse of 0x0400 followed by zero samples gives 0x0080, 0x0100, 0xFD00, 0x0500, 0x0400, 0x0500, 0xFD00, 0x0100 and 0x0080 on the nine strobes after the impulse strobe, then 0x0000.
- R3: `data_o` changes only at the clock edge that captures a strobe. On all other cycles it holds its value.
- R4: The history shifts only on a strobe. Idle cycles of any length between strobes do not change any later output.
- R5: The strobe may arrive every fourth cycle. With that minimum spacing, each output still includes all four accumulation steps.
- R6: The output loaded at strobe k+1 is sat(S). With h0 the sample taken at strobe k and h8 the oldest sample, the terms are pN = hN + h(8-N) and S = fl(p0/8) + fl(p1/4) - (fl(p2/2) + fl(p2/4)) + p3 + fl(p3/4) + h4. Here fl is the floor of the integer quotient.
- R7: Scaling truncates toward minus infinity. An impulse of 0xFFFF followed by zeros gives 0xFFFF, 0xFFFF, 0x0002, 0xFFFE, 0xFFFF, 0xFFFE, 0x0002, 0xFFFF and 0xFFFF on the nine following strobes.
- R8: A sum above 32767 is output as 0x7FFF, and a sum below -32768 is output as 0x8000.
- R9: The output loaded at a strobe reflects the samples up to the previous strobe only, not the sample being captured at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 1 | Strobe: capture `data_i` and load the output |
| data_i | input | 16 | Input sample, signed, 10 fraction bits |
| data_o | output | 16 | Filtered output, signed, 10 fraction bits |

## Verification
The assertions assume that strobes come at least four cycles apart, because the accumulation needs four edges after each capture. A checker counter flags any strobe closer than that. The bench drives every strobe through one task that takes the spacing as an argument, and it never gives a spacing below four. The minimum-spacing test uses exactly four, and the idle-gap tests stretch the spacing to show that waiting has no effect.

// File: rtl/fir_sym9_pkg.sv
// Package for the folded nine-tap filter.
// What it holds: the tap count, the schedule length and the per-step
// configuration of the shared shift-add unit.
// What it assumes: the fixed symmetric coefficient set
// 0.125 / 0.25 / -0.75 / 1.25 / 1.0 (centre).
package fir_sym9_pkg;

    localparam int TAPS   = 9;
    localparam int STEPS  = (TAPS - 1) / 2;
    localparam int CENTRE = TAPS / 2;
    localparam int PHW    = $clog2(STEPS);

    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_CENTRE  = 2'd1,
        SRC_QUARTER = 2'd2
    } second_src_e;

    typedef struct packed {
        logic [1:0]  shift;
        second_src_e src;
        logic        negate;
    } step_cfg_t;

    // Map a schedule step to the shift-add recipe for its coefficient pair.
    function automatic step_cfg_t step_cfg(input logic [PHW-1:0] ph);
        step_cfg_t c;
        case (ph)
            2'd0:    c = '{shift: 2'd3, src: SRC_CENTRE,  negate: 1'b0}; // 0.125 pair + centre
            2'd1:    c = '{shift: 2'd2, src: SRC_NONE,    negate: 1'b0}; // 0.25
            2'd2:    c = '{shift: 2'd1, src: SRC_QUARTER, negate: 1'b1}; // -(0.5+0.25)
            default: c = '{shift: 2'd0, src: SRC_QUARTER, negate: 1'b0}; // 1+0.25
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fir_sym9_tapline.sv
// History register for the filter.
// What it does: holds the last TAPS samples. Entry 0 is the newest.
// What it assumes: it shifts only when shift_i is high.
module fir_sym9_tapline #(
    parameter int DW   = 16,
    parameter int TAPS = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_i,
    input  logic signed [DW-1:0] din_i,
    output logic signed [DW-1:0] taps_o [TAPS]
);
    genvar g;
    generate
        for (g = 0; g < TAPS; g++) begin : g_tap
            // One history stage: clear on reset, take the neighbour on a strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    taps_o[g] <= '0;
                else if (shift_i)
                    taps_o[g] <= (g == 0) ? din_i : taps_o[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate
endmodule

// File: rtl/fir_sym9_sched.sv
// Step scheduler for the shared datapath.
// What it does: a strobe starts STEPS accumulation steps, one per cycle.
// What it assumes: strobes are at least STEPS cycles apart. A strobe that
// arrives early restarts the schedule.
module fir_sym9_sched #(
    parameter int STEPS = 4,
    parameter int PHW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    output logic           busy_o,
    output logic [PHW-1:0] ph_o
);
    localparam logic [PHW-1:0] LAST = PHW'(STEPS - 1);

    // Step counter: runs from 0 to LAST after each start, then goes idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            ph_o   <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            ph_o   <= '0;
        end else if (busy_o) begin
            busy_o <= (ph_o != LAST);
            ph_o   <= (ph_o == LAST) ? '0 : ph_o + 1'b1;
        end
    end
endmodule

// File: rtl/fir_sym9_datapath.sv
// Shared arithmetic for the filter.
// What it does: per step, one pre-adder folds a mirrored tap pair and one
// shift-add unit scales it. One accumulator adder then adds or subtracts
// the scaled term.
// What it assumes: the taps are stable while busy_i is high. acc_next_o is
// the value the sum has after the current step.
module fir_sym9_datapath
    import fir_sym9_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        busy_i,
    input  logic [PHW-1:0]              ph_i,
    input  logic signed [DW-1:0]        taps_i [TAPS],
    output logic signed [DW+GUARD-1:0]  acc_next_o
);
    localparam int AW = DW + GUARD;

    logic signed [DW-1:0] lo, hi;
    logic signed [AW-1:0] pair, scaled, second, term, acc;
    step_cfg_t            cfg;

    // Pair selection: step N folds tap N with tap TAPS-1-N.
    always_comb begin
        lo = '0;
        hi = '0;
        for (int i = 0; i < STEPS; i++) begin
            if (ph_i == PHW'(i)) begin
                lo = taps_i[i];
                hi = taps_i[TAPS-1-i];
            end
        end
    end

    // Pre-add, shift-add scaling and accumulate for the current step.
    always_comb begin
        cfg    = step_cfg(ph_i);
        pair   = AW'(lo) + AW'(hi);
        scaled = pair >>> cfg.shift;
        case (cfg.src)
            SRC_CENTRE:  second = AW'(taps_i[CENTRE]);
            SRC_QUARTER: second = pair >>> 2;
            default:     second = '0;
        endcase
        term = scaled + second;
        if (!busy_i)
            acc_next_o = acc;
        else if (cfg.negate)
            acc_next_o = acc - term;
        else
            acc_next_o = acc + term;
    end

    // Accumulator: cleared by a strobe, otherwise takes the stepped value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            acc <= '0;
        else
            acc <= acc_next_o;
    end
endmodule

// File: rtl/fir_sym9_outsat.sv
// Output stage.
// What it does: on a strobe, clamps the wide sum to the DW-bit signed range
// and registers it. Between strobes it holds.
// What it assumes: sum_i already includes the final step.
module fir_sym9_outsat #(
    parameter int DW = 16,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic signed [AW-1:0] sum_i,
    output logic signed [DW-1:0] q_o
);
    localparam logic signed [AW-1:0] HI = AW'((2 ** (DW - 1)) - 1);
    localparam logic signed [AW-1:0] LO = -HI - 1;

    logic signed [DW-1:0] clamped;

    // Saturate the wide sum into the output range.
    always_comb begin
        if (sum_i > HI)
            clamped = HI[DW-1:0];
        else if (sum_i < LO)
            clamped = LO[DW-1:0];
        else
            clamped = sum_i[DW-1:0];
    end

    // Output register: loads only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (load_i)
            q_o <= clamped;
    end
endmodule

// File: rtl/fir_sym9.sv
// Top level of the folded nine-tap FIR filter.
// What it does: captures a sample on each strobe, accumulates the folded
// weighted sum over STEPS cycles and presents it at the next strobe.
// What it assumes: strobes are at least STEPS cycles apart.
module fir_sym9
    import fir_sym9_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_i,
    input  logic signed [DW-1:0] data_i,
    output logic signed [DW-1:0] data_o
);
    localparam int AW = DW + GUARD;

    logic signed [DW-1:0] taps [TAPS];
    logic                 busy;
    logic [PHW-1:0]       ph;
    logic signed [AW-1:0] acc_next;

    fir_sym9_tapline #(.DW(DW), .TAPS(TAPS)) u_tap (
        .clk(clk), .rst_n(rst_n), .shift_i(sample_i), .din_i(data_i), .taps_o(taps)
    );

    fir_sym9_sched #(.STEPS(STEPS), .PHW(PHW)) u_sched (
        .clk(clk), .rst_n(rst_n), .start_i(sample_i), .busy_o(busy), .ph_o(ph)
    );

    fir_sym9_datapath #(.DW(DW), .GUARD(GUARD)) u_dp (
        .clk(clk), .rst_n(rst_n), .clear_i(sample_i), .busy_i(busy), .ph_i(ph),
        .taps_i(taps), .acc_next_o(acc_next)
    );

    fir_sym9_outsat #(.DW(DW), .AW(AW)) u_out (
        .clk(clk), .rst_n(rst_n), .load_i(sample_i), .sum_i(acc_next), .q_o(data_o)
    );
endmodule

// File: rtl/fir_sym9_chk.sv
// Checker for fir_sym9, bound into every instance.
// What it checks: the reset state, output hold, history shifting, strobe
// spacing and saturation.
// What it assumes: nothing beyond the port timing.
module fir_sym9_chk #(
    parameter int DW = 16,
    parameter int AW = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_i,
    input logic signed [DW-1:0] data_i,
    input logic signed [DW-1:0] data_o,
    input logic signed [DW-1:0] tap_first,
    input logic signed [DW-1:0] tap_second,
    input logic signed [DW-1:0] tap_last,
    input logic                 busy,
    input logic signed [AW-1:0] acc_next
);
    localparam logic signed [AW-1:0] HI = AW'((2 ** (DW - 1)) - 1);
    localparam logic signed [AW-1:0] LO = -HI - 1;

    logic [2:0] gap;
    logic       seen;

    // Spacing counter: cycles since the last strobe, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (sample_i) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 3'd7) begin
            gap <= gap + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (data_o == '0) && (tap_first == '0) && (tap_last == '0));

    p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(data_o));

    p_hist_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(tap_first) && $stable(tap_last));

    p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> (tap_first == $past(data_i)) && (tap_second == $past(tap_first)));

    p_sample_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && seen) |-> (gap >= 3'd3));

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> busy);

    p_sat_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (acc_next > HI)) |=> (data_o == HI[DW-1:0]));

    p_sat_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (acc_next < LO)) |=> (data_o == LO[DW-1:0]));
endmodule

bind fir_sym9 fir_sym9_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .data_i(data_i), .data_o(data_o),
    .tap_first(taps[0]), .tap_second(taps[1]), .tap_last(taps[TAPS-1]),
    .busy(busy), .acc_next(acc_next)
);

// File: tb/fir_sym9_tb.sv
// Directed bench for fir_sym9: one task per scenario, each checking itself.
module fir_sym9_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_i = 1'b0;
    logic signed [15:0] data_i = '0;
    logic signed [15:0] data_o;

    int n_chk = 0;
    int n_bad = 0;
    int hist [9];
    bit done = 0;

    fir_sym9 u_dut (.clk(clk), .rst_n(rst_n), .sample_i(sample_i), .data_i(data_i), .data_o(data_o));

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sum of R6 with floor scaling and R8 clamping.
    function automatic int model();
        int p0, p1, p2, p3, s;
        p0 = hist[0] + hist[8];
        p1 = hist[1] + hist[7];
        p2 = hist[2] + hist[6];
        p3 = hist[3] + hist[5];
        s  = (p0 >>> 3) + (p1 >>> 2) - ((p2 >>> 1) + (p2 >>> 2)) + p3 + (p3 >>> 2) + hist[4];
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    // Strobe one sample at the current negedge and check the output after the edge.
    // The next strobe comes gap cycles later.
    task automatic push(input logic signed [15:0] x, input int gap, input string req);
        int exp;
        exp = model();
        for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        sample_i = 1'b1;
        data_i   = x;
        @(negedge clk);
        sample_i = 1'b0;
        data_i   = 16'h5A5A;
        check(req, data_o, 16'(exp));
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset output", data_o, 16'h0000);
        rst_n = 1'b1;
        for (int i = 0; i < 9; i++) hist[i] = 0;
    endtask

    task automatic t_reset_r1();
        push(16'sh1234, 4, "R6 preload");
        push(16'sh0777, 4, "R6 preload");
        do_reset();
        for (int i = 0; i < 10; i++) push(16'sh0000, 4, "R1 zero after reset");
    endtask

    task automatic t_impulse_r2();
        logic [15:0] exp [10] = '{16'h0080, 16'h0100, 16'hFD00, 16'h0500, 16'h0400,
                                  16'h0500, 16'hFD00, 16'h0100, 16'h0080, 16'h0000};
        push(16'sh0400, 4, "R9 impulse strobe");
        for (int i = 0; i < 10; i++) begin
            push(16'sh0000, 4, "R2 model");
            check("R2 impulse literal", data_o, exp[i]);
        end
    endtask

    task automatic t_trunc_r7();
        logic [15:0] exp [9] = '{16'hFFFF, 16'hFFFF, 16'h0002, 16'hFFFE, 16'hFFFF,
                                 16'hFFFE, 16'h0002, 16'hFFFF, 16'hFFFF};
        push(-16'sd1, 4, "R7 strobe");
        for (int i = 0; i < 9; i++) begin
            push(16'sh0000, 4, "R7 model");
            check("R7 literal", data_o, exp[i]);
        end
    endtask

    task automatic t_hold_r3();
        logic [15:0] held;
        push(16'sh0400, 4, "R3 load");
        push(16'sh0200, 1, "R3 load");
        held = data_o;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R3 hold between strobes", data_o, held);
        end
    endtask

    task automatic t_gaps_r4();
        int g;
        for (int i = 0; i < 12; i++) begin
            g = 4 + (i * 7) % 13;
            push(16'(i * 300 - 1500), g, "R4 idle gap");
        end
    endtask

    task automatic t_min_spacing_r5();
        for (int i = 0; i < 12; i++)
            push(16'((i * 4111) ^ 16'h0C3A), 4, "R5 min spacing");
    endtask

    task automatic t_pattern_r6();
        for (int i = 0; i < 14; i++)
            push(16'((i * 2749 + 913) % 4096 - 2048), 5, "R6 pattern");
    endtask

    task automatic t_sat_r8();
        for (int i = 0; i < 10; i++) push(16'sh7FFF, 4, "R8 high");
        check("R8 clamp high", data_o, 16'h7FFF);
        for (int i = 0; i < 10; i++) push(-16'sh8000, 4, "R8 low");
        check("R8 clamp low", data_o, 16'h8000);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_reset_r1();
        t_impulse_r2();
        t_trunc_r7();
        t_hold_r3();
        t_gaps_r4();
        t_min_spacing_r5();
        t_pattern_r6();
        t_sat_r8();
        t_reset_r1();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule